// File: doc/BRIEF.md
# External Trigger Pulse Timer

This block is a timer whose counting is gated by an edge on an external input pin. Software selects which polarity of the pin starts the count and loads a compare value. Once started, a 16-bit counter advances on every cycle in which the prescaler tick input is high. When the counter equals the compare value on a tick, the counter clears, the timer re-arms and a one-cycle interrupt pulse follows.

A stop-enable mode lets the edge opposite to the trigger abort a count in progress. The counter clears and re-arms without any interrupt. The interrupt therefore fires only when the pin has held its triggered level for longer than the programmed width, which gives minimum pulse-width detection.

The pin is first passed through a two-stage synchronizer. A noise filter then accepts a new level only after it has persisted for a fixed number of cycles.

States of the sequencer:
- ST_IDLE: the run bit is clear and the counter is held at zero.
- ST_ARMED: waiting for the trigger edge.
- ST_COUNT: counting ticks.

Transitions:
- ST_IDLE to ST_ARMED, on run set.
- ST_ARMED to ST_COUNT, on the trigger edge.
- ST_COUNT to ST_ARMED, on a match (an interrupt follows).
- ST_COUNT to ST_ARMED, on an abort (opposite edge with stop enabled, no interrupt).
- Any state to ST_IDLE, on run cleared.

Top module: `ext_trig_timer`

## Requirements
- R1: After reset the interrupt output is low, the counter is zero and the sequencer is in ST_IDLE.
- R2: Control bit 1 picks the trigger polarity: 0 means a rising filtered edge starts counting, 1 means a falling one does.
- R3: In ST_COUNT the counter advances only in cycles where tick_i is high. A tick with the counter equal to the compare value is a match, so the match falls on the (compare+1)-th tick after the trigger edge.
- R4: The interrupt is a single-cycle pulse, high in the cycle after the match. On a match the counter clears and the sequencer returns to ST_ARMED.
- R5: After a match or an abort, the next trigger edge restarts counting from zero.
- R6: A trigger edge seen in ST_COUNT is ignored and neither restarts nor delays the count.
- R7: With control bit 2 (stop enable) at 0, the opposite edge has no effect on counting.
- R8: With stop enable at 1, an opposite edge in ST_COUNT clears the counter and returns to ST_ARMED with no interrupt. A match in the same cycle takes priority.
- R9: A synchronized pin level replaces the filtered level only after 8 consecutive cycles. Pulses of 4 cycles or fewer are rejected and pulses of 12 cycles or more are detected. A pin change made before clock edge k is seen by the sequencer at edge k+10.
- R10: Clearing control bit 0 (run) sends the sequencer to ST_IDLE, clears the counter and ignores pin edges while cleared. Setting it again enters ST_ARMED one cycle later, with no stored trigger.
- R11: Writes with wr_addr_i=0 load the control bits {stop enable, falling select, run} from wr_data_i[2:0]. Writes with wr_addr_i=1 load the 16-bit compare value.
- R12: A compare value of zero matches on the first tick after the trigger edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External trigger pin, asynchronous |
| tick_i | input | 1 | Count-enable tick from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects control, 1 selects compare |
| wr_data_i | input | 16 | Write data |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions make only two assumptions: reset is held low from time zero, and the pin and tick inputs change only away from the active clock edge. The tick may follow any pattern, and register writes may land in any state. The stimulus drives every input on the falling clock edge. It spaces pin changes by at least twelve cycles, except for deliberate noise pulses of four cycles, so that each intended edge passes the filter exactly once. Writes are issued while the sequencer is armed or counting, to exercise run clearing mid-count.

// File: rtl/ett_pkg.sv
package ett_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } ett_state_e;

    // control field positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_FALL = 1;
    localparam int CTL_STOP = 2;
    localparam int CTL_W    = 3;

endpackage

// File: rtl/ett_pin_filter.sv
module ett_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int FILT_W = $clog2(FILT_CYC) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   level_q;
    logic                   level_d1_q;
    logic [FILT_W-1:0]      run_q;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            level_d1_q <= 1'b0;
            run_q      <= '0;
        end else begin
            level_d1_q <= level_q;
            if (synced == level_q) begin
                run_q <= '0;
            end else if (run_q == FILT_W'(FILT_CYC - 1)) begin
                level_q <= synced;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign rise_o = level_q & ~level_d1_q;
    assign fall_o = ~level_q & level_d1_q;

    // R9
    level_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> (level_q == $past(synced)));

    // R9
    level_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (synced != level_q && run_q < FILT_W'(FILT_CYC - 1)) |=> $stable(level_q));

endmodule

// File: rtl/ett_core.sv
module ett_core
    import ett_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             fall_sel_i,
    input  logic             stop_en_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             tick_i,
    output logic             irq_o
);
    ett_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             trig, opp;
    logic             match, abort, cnt_clr, cnt_inc;

    assign trig = fall_sel_i ? fall_i : rise_i;
    assign opp  = fall_sel_i ? rise_i : fall_i;

    always_comb begin
        state_d = state_q;
        match   = 1'b0;
        abort   = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (run_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (trig) begin
                    state_d = ST_COUNT;
                    cnt_clr = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (tick_i && cnt_q == cmp_i) begin
                    match   = 1'b1;
                    state_d = ST_ARMED;
                    cnt_clr = 1'b1;
                end else if (stop_en_i && opp) begin
                    abort   = 1'b1;
                    state_d = ST_ARMED;
                    cnt_clr = 1'b1;
                end else if (tick_i) begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= match;
    end

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    run_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_IDLE && !irq_o && cnt_q == '0));

    // R6
    retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && run_i && trig && !tick_i && !(stop_en_i && opp))
        |=> (state_q == ST_COUNT && cnt_q == $past(cnt_q)));

    // R8
    abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && run_i && stop_en_i && opp && !(tick_i && cnt_q == cmp_i))
        |=> (state_q == ST_ARMED && !irq_o && cnt_q == '0));

    // R3
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && run_i && !tick_i && !(stop_en_i && opp)) |=> $stable(cnt_q));

    // R4
    match_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (state_q == ST_ARMED && cnt_q == '0));

endmodule

// File: rtl/ext_trig_timer.sv
module ext_trig_timer
    import ett_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             irq_o
);
    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             rise, fall;

    // R11
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cmp_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i) cmp_q <= wr_data_i;
            else           ctl_q <= wr_data_i[CTL_W-1:0];
        end
    end

    ett_pin_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_CYC   (FILT_CYC)
    ) i_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    ett_core #(
        .CNT_W(CNT_W)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q[CTL_RUN]),
        .fall_sel_i(ctl_q[CTL_FALL]),
        .stop_en_i (ctl_q[CTL_STOP]),
        .cmp_i     (cmp_q),
        .rise_i    (rise),
        .fall_i    (fall),
        .tick_i    (tick_i),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/test_ext_trig_timer.sv
module test_ext_trig_timer;
    localparam int FILT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    int tick_per = 1;
    int tdiv = 0;
    bit done = 0;
    string cur_req = "R1";

    ext_trig_timer i_ext_trig_timer (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .tick_i(tick),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // tick generator
    always @(negedge clk) begin
        tick = (tdiv == 0);
        tdiv = (tdiv + 1) % tick_per;
    end

    // behavioural reference model
    bit pin_hist[$] = '{1'b0, 1'b0};
    int m_len = 0;
    bit m_lvl = 0, m_lvl_prev = 0;
    bit m_live = 0, m_busy = 0, m_irq = 0;
    int m_cnt = 0, m_cmp = 0;
    bit [2:0] m_ctl = 0;

    always @(posedge clk) begin
        cycle++;
        if (!rst_n) begin
            pin_hist = '{1'b0, 1'b0};
            m_len = 0; m_lvl = 0; m_lvl_prev = 0;
            m_live = 0; m_busy = 0; m_irq = 0;
            m_cnt = 0; m_cmp = 0; m_ctl = 0;
        end else begin
            bit up, dn, st, op, hit, seen, old_lvl;
            up = m_lvl && !m_lvl_prev;
            dn = !m_lvl && m_lvl_prev;
            st = m_ctl[1] ? dn : up;
            op = m_ctl[1] ? up : dn;
            hit = 0;
            if (!m_ctl[0]) begin
                m_live = 0; m_busy = 0; m_cnt = 0;
            end else if (!m_live) begin
                m_live = 1;
            end else if (!m_busy) begin
                if (st) begin m_busy = 1; m_cnt = 0; end
            end else begin
                if (tick && m_cnt == m_cmp) begin
                    hit = 1; m_busy = 0; m_cnt = 0;
                end else if (m_ctl[2] && op) begin
                    m_busy = 0; m_cnt = 0;
                end else if (tick) begin
                    m_cnt++;
                end
            end
            m_irq = hit;
            seen = pin_hist[0];
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin);
            old_lvl = m_lvl;
            if (seen == m_lvl) m_len = 0;
            else if (m_len == FILT - 1) begin m_lvl = seen; m_len = 0; end
            else m_len++;
            m_lvl_prev = old_lvl;
            if (wr_en) begin
                if (wr_addr) m_cmp = int'(wr_data);
                else m_ctl = wr_data[2:0];
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL %s model: irq=%0b expected %0b (cycle %0d)", cur_req, irq, m_irq, cycle);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input int d);
        wr_en = 1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic watch(input int n, output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (irq) begin
                if (first < 0) first = i;
                cnt++;
            end
        end
    endtask

    task automatic drive(input bit v, input int n, output int first, output int cnt);
        pin = v;
        watch(n, first, cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f, c, f2, c2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq during reset", irq, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 irq after reset", irq, 0);

        // R11 R3 R2 basic rising trigger, sparse ticks
        cur_req = "R3";
        tick_per = 3; tdiv = 0;
        wr(1, 5);
        wr(0, 3'b001);
        watch(5, f, c);
        drive(1, 60, f, c);
        check("R3 one irq after rising trigger", c, 1);
        cur_req = "R7";
        drive(0, 40, f, c);
        check("R7 opposite edge no effect", c, 0);
        cur_req = "R5";
        drive(1, 60, f, c);
        check("R5 restart after match", c, 1);
        drive(0, 30, f, c);

        tick_per = 1; tdiv = 0;
        watch(5, f, c);

        // R12 compare zero
        cur_req = "R12";
        wr(1, 0);
        watch(3, f, c);
        drive(1, 30, f, c);
        check("R12 irq cycle for compare 0", f, 12);
        check("R4 single pulse", c, 1);
        drive(0, 20, f, c);

        // R6 retrigger ignored, R7 falling edge ignored
        cur_req = "R6";
        wr(1, 30);
        watch(3, f, c);
        drive(1, 12, f, c);
        drive(0, 12, f2, c2);
        check("R6 no early irq", c + c2, 0);
        drive(1, 40, f, c);
        check("R6 irq timing unchanged by retrigger", f, 18);
        drive(0, 20, f, c);

        // R8 R2 falling trigger with stop enable
        cur_req = "R8";
        wr(0, 3'b111);
        drive(1, 30, f, c);
        check("R2 rising edge does not trigger in falling mode", c, 0);
        drive(0, 20, f, c);
        drive(1, 60, f2, c2);
        check("R8 short pulse aborted silently", c + c2, 0);
        drive(0, 60, f, c);
        check("R8 long low pulse raises irq", f, 42);
        check("R2 falling trigger count", c, 1);
        drive(1, 20, f, c);

        // R9 noise filter
        cur_req = "R9";
        wr(0, 3'b001);
        wr(1, 0);
        drive(0, 20, f, c);
        drive(1, 4, f, c);
        drive(0, 40, f2, c2);
        check("R9 4-cycle pulse rejected", c + c2, 0);
        drive(1, 12, f, c);
        drive(0, 30, f2, c2);
        check("R9 12-cycle pulse detected", c + c2, 1);

        // R10 run clear
        cur_req = "R10";
        wr(1, 30);
        drive(1, 20, f, c);
        wr(0, 3'b000);
        watch(40, f, c);
        check("R10 clear run halts count", c, 0);
        drive(0, 15, f, c);
        drive(1, 15, f, c);
        wr(0, 3'b001);
        watch(60, f, c);
        check("R10 edges while stopped discarded", c, 0);
        drive(0, 15, f, c);
        drive(1, 50, f, c);
        check("R10 counts again after re-enable", f, 42);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule